// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. A down-counter runs from a programmable start value. When it reaches zero, an interrupt is raised and the counter starts again from the start value. If software has still not serviced the interrupt when the counter hits zero a second time, a one-cycle system reset pulse is issued, provided reset generation is enabled. Software services the watchdog by writing the interrupt-clear register, which drops the interrupt and restarts the count.

Every register that changes behaviour is write-protected by a key register. A stray store cannot stop the timer, change its period or service it unless the exact key was written first. Any other value written to the key register protects the registers again. Reads are never blocked. The register bus is a plain single-cycle interface: address, write strobe, write data and combinational read data.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the block is protected, counting is stopped, the start value and the count both read 0xFFFFFFFF, the control register reads 0, and both `irq` and `sys_rst` are low.
- R2: Writing 0x1ACCE551 to the key register at 0xC00 removes protection. Writing any other value there restores it. The key register can be written at any time, and it reads 1 while protected and 0 while open.
- R3: While the block is protected, writes to the start value (0x000), control (0x008) and interrupt-clear (0x00C) registers change nothing that can be observed.
- R4: The control register at 0x008 uses bit 1 to enable counting together with the interrupt, and bit 0 to enable the reset pulse. Bits 31:2 always read 0.
- R5: While counting is enabled, the count decreases by one on every clock. It can be read at 0x004, and writes to 0x004 are ignored.
- R6: When the count is zero and counting is enabled, the next clock reloads it from the start value and counting continues, so one period lasts start value + 1 clocks.
- R7: The first expiry sets `irq`. The status register at 0x014 reads 1 while it is set and 0 otherwise.
- R8: An expiry that occurs while `irq` is already set, with bit 0 of control set, drives `sys_rst` high for exactly one clock. The pulse starts on the same edge that reloads the count.
- R9: After a pulse, no further pulse is issued until the interrupt is cleared. When bit 0 of control is 0, no pulse is issued at all.
- R10: Writing a value with bit 0 set to 0x00C clears `irq` and reloads the count from the start value on that edge. Such a write with bit 0 clear has no effect.
- R11: Clearing bit 1 of control freezes the count. Setting it again resumes counting from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Watchdog interrupt (level) |
| sys_rst | output | 1 | System reset request, one-cycle pulse |

## Verification
A count that is off by one in either direction shifts every interrupt and reset edge by a clock per period. A count read at 0x004 exposes the error immediately, and the outputs show it within one period. A wrong protection flag shows up on the next write: either the key register reads back the wrong value, or a protected write changes the start value or the control register. A stuck or missing record that a reset was already issued shows up one period after the first pulse, as an extra `sys_rst` pulse, or as no pulse when one is expected. The sweep over small start values, including zero, checks the exact edges of both stages.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
   localparam int unsigned BUS_W = 32;

   localparam logic [11:0] OFS_START  = 12'h000;
   localparam logic [11:0] OFS_COUNT  = 12'h004;
   localparam logic [11:0] OFS_CTRL   = 12'h008;
   localparam logic [11:0] OFS_SVC    = 12'h00C;
   localparam logic [11:0] OFS_STAT   = 12'h014;
   localparam logic [11:0] OFS_KEY    = 12'hC00;

   localparam logic [BUS_W-1:0] OPEN_KEY = 32'h1ACC_E551;

   localparam int unsigned CTRL_RST_BIT = 0;
   localparam int unsigned CTRL_RUN_BIT = 1;

   typedef struct packed {
      logic run;
      logic rst_en;
   } ctrl_t;
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
   import keyed_wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] START_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   output logic              is_open,
   output logic [CNT_W-1:0]  start_val,
   output ctrl_t             ctrl,
   output logic              svc_pulse
);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SVC   = ADDR_W'(OFS_SVC);
   localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);

   logic wr_ok;
   assign wr_ok = wr_en && is_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
      end else if (wr_en && addr == A_KEY) begin
         is_open <= (wr_data == OPEN_KEY);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_val <= START_RST;
      end else if (wr_ok && addr == A_START) begin
         start_val <= wr_data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ok && addr == A_CTRL) begin
         ctrl.run    <= wr_data[CTRL_RUN_BIT];
         ctrl.rst_en <= wr_data[CTRL_RST_BIT];
      end
   end

   assign svc_pulse = wr_ok && (addr == A_SVC) && wr_data[0];

   // R3
   locked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_open && wr_en && addr == A_START) |=> $stable(start_val));
   // R3
   locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_open && wr_en && addr == A_CTRL) |=> $stable(ctrl));
   // R2
   key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_KEY && wr_data != OPEN_KEY) |=> !is_open);
endmodule

// File: rtl/keyed_wdog_counter.sv
module keyed_wdog_counter #(
   parameter int unsigned CNT_W = 32,
   parameter logic [CNT_W-1:0] CNT_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [CNT_W-1:0] start_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_RST;
      end else if (reload || expire) begin
         cnt <= start_val;
      end else if (run) begin
         cnt <= cnt - ONE;
      end
   end

   // R5
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != '0 && !reload) |=> cnt == $past(cnt) - ONE);
   // R11
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reload) |=> $stable(cnt));
   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> cnt == $past(start_val));
endmodule

// File: rtl/keyed_wdog_stage.sv
module keyed_wdog_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic svc,
   input  logic rst_en,
   output logic irq,
   output logic sys_rst
);
   logic fired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         fired   <= 1'b0;
         sys_rst <= 1'b0;
      end else if (svc) begin
         irq     <= 1'b0;
         fired   <= 1'b0;
         sys_rst <= 1'b0;
      end else begin
         sys_rst <= 1'b0;
         if (expire) begin
            if (!irq) begin
               irq <= 1'b1;
            end else if (rst_en && !fired) begin
               sys_rst <= 1'b1;
               fired   <= 1'b1;
            end
         end
      end
   end

   // R8
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> !sys_rst);
   // R8
   pulse_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> irq);
   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(expire));
   // R9
   no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rst && !svc) |=> !sys_rst);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import keyed_wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] START_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              irq,
   output logic              sys_rst
);
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("keyed_wdog: CNT_W must lie in 2..32");
   end
   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("keyed_wdog: ADDR_W must be at least 12");
   end

   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);

   logic             is_open;
   logic [CNT_W-1:0] start_val;
   ctrl_t            ctrl;
   logic             svc_pulse;
   logic [CNT_W-1:0] cnt;
   logic             expire;
   logic [BUS_W-1:0] cnt_ext;
   logic [BUS_W-1:0] start_ext;

   keyed_wdog_regs #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .START_RST (START_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .is_open   (is_open),
      .start_val (start_val),
      .ctrl      (ctrl),
      .svc_pulse (svc_pulse)
   );

   keyed_wdog_counter #(
      .CNT_W   (CNT_W),
      .CNT_RST (START_RST)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl.run),
      .reload    (svc_pulse),
      .start_val (start_val),
      .cnt       (cnt),
      .expire    (expire)
   );

   keyed_wdog_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .svc     (svc_pulse),
      .rst_en  (ctrl.rst_en),
      .irq     (irq),
      .sys_rst (sys_rst)
   );

   if (CNT_W == BUS_W) begin : g_full
      assign cnt_ext   = cnt;
      assign start_ext = start_val;
   end else begin : g_pad
      assign cnt_ext   = {{(BUS_W-CNT_W){1'b0}}, cnt};
      assign start_ext = {{(BUS_W-CNT_W){1'b0}}, start_val};
   end

   always_comb begin
      rd_data = '0;
      unique case (addr)
         A_START: rd_data = start_ext;
         A_COUNT: rd_data = cnt_ext;
         A_CTRL: begin
            rd_data[CTRL_RUN_BIT] = ctrl.run;
            rd_data[CTRL_RST_BIT] = ctrl.rst_en;
         end
         A_STAT:  rd_data[0] = irq;
         A_KEY:   rd_data[0] = !is_open;
         default: rd_data = '0;
      endcase
   end

   // R4
   ctrl_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_CTRL) |-> rd_data[31:2] == '0);
endmodule

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_START = 12'h000;
   localparam logic [11:0] A_COUNT = 12'h004;
   localparam logic [11:0] A_CTRL  = 12'h008;
   localparam logic [11:0] A_SVC   = 12'h00C;
   localparam logic [11:0] A_STAT  = 12'h014;
   localparam logic [11:0] A_KEY   = 12'hC00;
   localparam logic [31:0] KEY     = 32'h1ACC_E551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;
   logic        sys_rst;

   int total = 0;
   int bad = 0;
   int rst_seen = 0;
   logic [31:0] v;

   keyed_wdog dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq     (irq),
      .sys_rst (sys_rst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (sys_rst) rst_seen++;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic run_case(input int sv, input bit rsten);
      int base;
      wr(A_KEY, KEY);
      wr(A_START, 32'(sv));
      wr(A_SVC, 32'h1);
      wr(A_CTRL, {30'd0, 1'b1, rsten});
      base = rst_seen;
      rd(A_COUNT, v); chk("R5 start", v, 32'(sv));
      repeat (sv) @(negedge clk);
      rd(A_COUNT, v); chk("R5 reach zero", v, 32'd0);
      chk("R7 no early irq", {31'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R7 first expiry irq", {31'd0, irq}, 32'd1);
      rd(A_STAT, v); chk("R7 status", v, 32'd1);
      rd(A_COUNT, v); chk("R6 reload", v, 32'(sv));
      chk("R8 no pulse first", {31'd0, sys_rst}, 32'd0);
      repeat (sv) @(negedge clk);
      chk("R8 no early pulse", {31'd0, sys_rst}, 32'd0);
      @(negedge clk);
      chk("R8 second expiry", {31'd0, sys_rst}, {31'd0, rsten});
      @(negedge clk);
      chk("R8 one cycle", {31'd0, sys_rst}, 32'd0);
      repeat (sv) @(negedge clk);
      chk("R9 pulse count", 32'(rst_seen - base), {31'd0, rsten});
      chk("R9 irq held", {31'd0, irq}, 32'd1);
      wr(A_SVC, 32'h2);
      chk("R10 bit0 clear ignored", {31'd0, irq}, 32'd1);
      wr(A_SVC, 32'h1);
      chk("R10 clear irq", {31'd0, irq}, 32'd0);
      rd(A_COUNT, v); chk("R10 reload", v, 32'(sv));
      wr(A_CTRL, 32'h0);
      wr(A_KEY, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(A_START, v); chk("R1 start", v, 32'hFFFF_FFFF);
      rd(A_COUNT, v); chk("R1 count", v, 32'hFFFF_FFFF);
      rd(A_CTRL, v);  chk("R1 ctrl", v, 32'd0);
      @(negedge clk);
      rd(A_STAT, v);  chk("R1 status", v, 32'd0);
      rd(A_KEY, v);   chk("R1 locked", v, 32'd1);
      chk("R1 outputs", {30'd0, irq, sys_rst}, 32'd0);
      // R2 / R3 protection
      wr(A_KEY, 32'h1234_5678);
      rd(A_KEY, v);   chk("R2 wrong key", v, 32'd1);
      wr(A_START, 32'd5);
      rd(A_START, v); chk("R3 locked start", v, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'd3);
      rd(A_CTRL, v);  chk("R3 locked ctrl", v, 32'd0);
      rd(A_COUNT, v); chk("R3 still stopped", v, 32'hFFFF_FFFF);
      wr(A_KEY, KEY);
      rd(A_KEY, v);   chk("R2 open", v, 32'd0);
      wr(A_CTRL, 32'hFFFF_FFFC);
      rd(A_CTRL, v);  chk("R4 reserved", v, 32'd0);
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, v);  chk("R4 both bits", v, 32'd3);
      wr(A_CTRL, 32'd0);
      wr(A_COUNT, 32'd7);
      rd(A_COUNT, v); chk("R5 count write ignored", v, 32'hFFFF_FFFF - 32'd1);
      wr(A_KEY, 32'd0);
      rd(A_KEY, v);   chk("R2 relock", v, 32'd1);

      // sweep of small start values, both reset settings
      for (int sv = 0; sv <= 6; sv++) begin
         run_case(sv, 1'b0);
         run_case(sv, 1'b1);
      end

      // R11 freeze and resume
      wr(A_KEY, KEY);
      wr(A_START, 32'd20);
      wr(A_SVC, 32'h1);
      wr(A_CTRL, 32'd2);
      repeat (5) @(negedge clk);
      rd(A_COUNT, v); chk("R11 running", v, 32'd15);
      wr(A_CTRL, 32'd0);
      repeat (4) @(negedge clk);
      rd(A_COUNT, v); chk("R11 frozen", v, 32'd14);
      wr(A_CTRL, 32'd2);
      rd(A_COUNT, v); chk("R11 resume point", v, 32'd14);
      repeat (3) @(negedge clk);
      rd(A_COUNT, v); chk("R11 resumed", v, 32'd11);

      // R3 locked service write while irq pending
      wr(A_START, 32'd2);
      wr(A_SVC, 32'h1);
      repeat (3) @(negedge clk);
      chk("R7 irq for lock test", {31'd0, irq}, 32'd1);
      wr(A_CTRL, 32'd0);
      rd(A_COUNT, v);
      wr(A_KEY, 32'hDEAD_BEEF);
      wr(A_SVC, 32'h1);
      chk("R3 locked service", {31'd0, irq}, 32'd1);
      rd(A_COUNT, wr_data);
      chk("R3 locked service count", wr_data, v);
      wr(A_KEY, KEY);
      wr(A_SVC, 32'h1);
      chk("R10 open service", {31'd0, irq}, 32'd0);
      rd(A_COUNT, v); chk("R10 open reload", v, 32'd2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule